// File: doc/BRIEF.md
# Dual-Processor Message FIFO Channel

This block links two processors, called side A and side B, through two independent one-way queues of 32-bit words, one queue for each direction. Each side has a 16-bit control/status register, a send port and a receive port. A word pushed on one side's send port comes out of the other side's receive port, oldest first. Each side's status word shows both the state of its own outgoing queue and the state of the queue arriving from the other side. Because of this, either processor can tell whether its partner has drained or filled a queue without any handshake in software.

Pushing into a full queue and popping an empty one are rejected. Either case raises a sticky error flag, which software clears by writing a one to it. A side can flush its own outgoing queue through a strobe bit in the control word. Each side has two single-cycle interrupt requests. One fires when its outgoing queue has just drained. The other fires when its incoming queue has just received its first word. Bus address decoding and the system interrupt controller sit outside this block.

Received data is combinational. `x_pop_data` carries the head word in the same cycle that `x_pop` is high, and the queue advances at the next rising clock edge. Control writes, pushes and pops all take effect at that edge.

Top module: `mbx_top`

## Requirements
- R1: Each direction stores up to 16 words of 32 bits and delivers them in the order they were pushed. The read and write positions wrap from the last slot back to the first, so any sequence of fill and drain lengths keeps that order.
- R2: A queue reports full when it holds 16 words and empty when it holds none. A push to a full queue leaves the queue full and unchanged.
- R3: Control bit 15 enables the side. While that bit is 0, a push on that side is ignored, and a pop returns 0, changes nothing and raises no error.
- R4: Status bit 0 is send-empty and bit 1 is send-full for the side's outgoing queue. Bit 8 is receive-empty and bit 9 is receive-full for its incoming queue. Bits 8 and 9 of one side always equal bits 0 and 1 of the other side.
- R5: On an enabled side, a push while the outgoing queue is full or a pop while the incoming queue is empty sets error bit 14. The queue contents do not change, and such a pop returns 0.
- R6: The error bit stays set until its side writes the control word with bit 14 equal to 1. A control write with bit 14 equal to 0 leaves it set.
- R7: A control write with bit 3 equal to 1 empties that side's outgoing queue at once. Its bit 0 and the other side's bit 8 read 1 in the next cycle, and a word pushed afterwards is the first one delivered. Bit 3 always reads 0.
- R8: Only bits 15, 10 and 2 of a control write are stored. All other written bits are dropped, apart from the two strobes (bit 14 clears the error, bit 3 flushes). Writing 0xFFF7 to an empty, error-free side reads back 0x8505.
- R9: After reset both control words read 0x0101, and all four interrupt outputs are 0.
- R10: A push by one side and a pop by the other side on the same non-empty, non-full queue in the same cycle both complete, and the queue's occupancy does not change.
- R11: When bit 2 is 1 and the outgoing queue goes from non-empty to empty, `x_irq_send_empty` goes high for exactly one cycle, the cycle after the emptying edge.
- R12: When bit 10 is 1 and the incoming queue goes from empty to non-empty, `x_irq_recv` goes high for exactly one cycle, the cycle after the push edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_ctl_we | input | 1 | Side A control write strobe |
| a_ctl_wdata | input | 16 | Side A control write value |
| a_ctl_rdata | output | 16 | Side A control/status word |
| a_push | input | 1 | Side A push request |
| a_push_data | input | 32 | Side A word to send |
| a_pop | input | 1 | Side A pop request |
| a_pop_data | output | 32 | Word received by side A (0 when the pop is refused) |
| a_irq_send_empty | output | 1 | Side A outgoing-drained interrupt pulse |
| a_irq_recv | output | 1 | Side A incoming-arrived interrupt pulse |
| b_ctl_we | input | 1 | Side B control write strobe |
| b_ctl_wdata | input | 16 | Side B control write value |
| b_ctl_rdata | output | 16 | Side B control/status word |
| b_push | input | 1 | Side B push request |
| b_push_data | input | 32 | Side B word to send |
| b_pop | input | 1 | Side B pop request |
| b_pop_data | output | 32 | Word received by side B (0 when the pop is refused) |
| b_irq_send_empty | output | 1 | Side B outgoing-drained interrupt pulse |
| b_irq_recv | output | 1 | Side B incoming-arrived interrupt pulse |

## Verification
A wrong pointer or occupancy value shows up in two ways: status bits that differ from a simple count of words pushed minus words popped, and received words that arrive out of order or duplicated. Either is visible on the first pop or status read after the bad update. A cross-mirroring fault appears at once as a mismatch between one side's send flags and the other side's receive flags. Errors in the interrupt edge detectors show as a missing pulse, a pulse lasting two cycles or a pulse on the wrong transition, in the cycle right after the push or pop that caused the transition. Fill and drain runs of many lengths move the wrap point to every slot, so a wrap fault surfaces within a few rounds.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Control/status bit positions (software-visible layout)
  localparam int BIT_SEND_EMPTY = 0;
  localparam int BIT_SEND_FULL  = 1;
  localparam int BIT_IE_DRAIN   = 2;
  localparam int BIT_FLUSH      = 3;
  localparam int BIT_RECV_EMPTY = 8;
  localparam int BIT_RECV_FULL  = 9;
  localparam int BIT_IE_ARRIVE  = 10;
  localparam int BIT_ERROR      = 14;
  localparam int BIT_ENABLE     = 15;

  localparam int CTL_W   = 16;
  localparam int N_SIDES = 2;

  typedef struct packed {
    logic enable;
    logic ie_drain;
    logic ie_arrive;
    logic error;
  } side_cfg_t;

  function automatic logic [CTL_W-1:0] pack_status(
    input side_cfg_t cfg,
    input logic      send_empty,
    input logic      send_full,
    input logic      recv_empty,
    input logic      recv_full
  );
    logic [CTL_W-1:0] r;
    r                 = '0;
    r[BIT_ENABLE]     = cfg.enable;
    r[BIT_ERROR]      = cfg.error;
    r[BIT_IE_ARRIVE]  = cfg.ie_arrive;
    r[BIT_RECV_FULL]  = recv_full;
    r[BIT_RECV_EMPTY] = recv_empty;
    r[BIT_IE_DRAIN]   = cfg.ie_drain;
    r[BIT_SEND_FULL]  = send_full;
    r[BIT_SEND_EMPTY] = send_empty;
    return r;
  endfunction

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push_i,
  input  logic [WIDTH-1:0]                 push_data_i,
  input  logic                             pop_i,
  input  logic                             flush_i,
  output logic [WIDTH-1:0]                 head_o,
  output logic [$clog2(DEPTH+1)-1:0]       count_o,
  output logic                             empty_o,
  output logic                             full_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAPACITY  = CW'(DEPTH);

  logic [WIDTH-1:0] store_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             ptr_en;
  logic             store_en;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // next-state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push_i) wr_ptr_d = step(wr_ptr_q);
      if (pop_i)  rd_ptr_d = step(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  assign ptr_en   = flush_i | push_i | pop_i;
  assign store_en = push_i & ~flush_i;

  // pointer and occupancy registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // storage: no reset, written only with its enable
  always_ff @(posedge clk) begin
    if (store_en) begin
      store_q[wr_ptr_q] <= push_data_i;
    end
  end

  assign head_o  = store_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CAPACITY);

endmodule

// File: rtl/mbx_side_ctl.sv
module mbx_side_ctl
  import mbx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             push_req_i,
  input  logic             pop_req_i,
  input  logic             out_empty_i,
  input  logic             out_full_i,
  input  logic             in_empty_i,
  input  logic             in_full_i,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             flush_o,
  output logic [CTL_W-1:0] ctl_rdata_o,
  output logic             irq_drain_o,
  output logic             irq_arrive_o
);

  side_cfg_t cfg_q, cfg_d;
  logic      cfg_en;
  logic      fault;
  logic      out_was_empty_q;
  logic      in_was_empty_q;

  // request qualification
  always_comb begin
    push_ok_o = cfg_q.enable & push_req_i & ~out_full_i;
    pop_ok_o  = cfg_q.enable & pop_req_i  & ~in_empty_i;
    fault     = cfg_q.enable & ((push_req_i & out_full_i) | (pop_req_i & in_empty_i));
    flush_o   = ctl_we_i & ctl_wdata_i[BIT_FLUSH];
  end

  // configuration next-state; a fault in the same cycle wins over a clear
  always_comb begin
    cfg_d = cfg_q;
    if (ctl_we_i) begin
      cfg_d.enable    = ctl_wdata_i[BIT_ENABLE];
      cfg_d.ie_drain  = ctl_wdata_i[BIT_IE_DRAIN];
      cfg_d.ie_arrive = ctl_wdata_i[BIT_IE_ARRIVE];
      if (ctl_wdata_i[BIT_ERROR]) cfg_d.error = 1'b0;
    end
    if (fault) cfg_d.error = 1'b1;
  end

  assign cfg_en = ctl_we_i | fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  // edge history for the interrupt pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_was_empty_q <= 1'b1;
      in_was_empty_q  <= 1'b1;
    end else begin
      out_was_empty_q <= out_empty_i;
      in_was_empty_q  <= in_empty_i;
    end
  end

  assign irq_drain_o  = cfg_q.ie_drain  &  out_empty_i & ~out_was_empty_q;
  assign irq_arrive_o = cfg_q.ie_arrive & ~in_empty_i  &  in_was_empty_q;

  assign ctl_rdata_o = pack_status(cfg_q, out_empty_i, out_full_i, in_empty_i, in_full_i);

endmodule

// File: rtl/mbx_top.sv
module mbx_top
  import mbx_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_ctl_we,
  input  logic [15:0]      a_ctl_wdata,
  output logic [15:0]      a_ctl_rdata,
  input  logic             a_push,
  input  logic [WIDTH-1:0] a_push_data,
  input  logic             a_pop,
  output logic [WIDTH-1:0] a_pop_data,
  output logic             a_irq_send_empty,
  output logic             a_irq_recv,
  input  logic             b_ctl_we,
  input  logic [15:0]      b_ctl_wdata,
  output logic [15:0]      b_ctl_rdata,
  input  logic             b_push,
  input  logic [WIDTH-1:0] b_push_data,
  input  logic             b_pop,
  output logic [WIDTH-1:0] b_pop_data,
  output logic             b_irq_send_empty,
  output logic             b_irq_recv
);

  localparam int CW = $clog2(DEPTH + 1);

  logic                              rst_n_sync;
  logic [N_SIDES-1:0]                side_ctl_we;
  logic [N_SIDES-1:0][CTL_W-1:0]     side_ctl_wdata;
  logic [N_SIDES-1:0][CTL_W-1:0]     side_ctl_rdata;
  logic [N_SIDES-1:0]                side_push;
  logic [N_SIDES-1:0][WIDTH-1:0]     side_push_data;
  logic [N_SIDES-1:0]                side_pop;
  logic [N_SIDES-1:0][WIDTH-1:0]     side_pop_data;
  logic [N_SIDES-1:0]                side_irq_drain;
  logic [N_SIDES-1:0]                side_irq_arrive;
  logic [N_SIDES-1:0]                side_push_ok;
  logic [N_SIDES-1:0]                side_pop_ok;
  logic [N_SIDES-1:0]                side_flush;
  // queue index g carries words sent by side g
  logic [N_SIDES-1:0][WIDTH-1:0]     fifo_head;
  logic [N_SIDES-1:0][CW-1:0]        fifo_cnt;
  logic [N_SIDES-1:0]                fifo_empty;
  logic [N_SIDES-1:0]                fifo_full;

  mbx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // port mapping onto side-indexed buses
  assign side_ctl_we    = {b_ctl_we,    a_ctl_we};
  assign side_ctl_wdata = {b_ctl_wdata, a_ctl_wdata};
  assign side_push      = {b_push,      a_push};
  assign side_push_data = {b_push_data, a_push_data};
  assign side_pop       = {b_pop,       a_pop};

  assign a_ctl_rdata      = side_ctl_rdata[0];
  assign b_ctl_rdata      = side_ctl_rdata[1];
  assign a_pop_data       = side_pop_data[0];
  assign b_pop_data       = side_pop_data[1];
  assign a_irq_send_empty = side_irq_drain[0];
  assign b_irq_send_empty = side_irq_drain[1];
  assign a_irq_recv       = side_irq_arrive[0];
  assign b_irq_recv       = side_irq_arrive[1];

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    localparam int PEER = N_SIDES - 1 - g;

    mbx_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n_sync),
      .push_i      (side_push_ok[g]),
      .push_data_i (side_push_data[g]),
      .pop_i       (side_pop_ok[PEER]),
      .flush_i     (side_flush[g]),
      .head_o      (fifo_head[g]),
      .count_o     (fifo_cnt[g]),
      .empty_o     (fifo_empty[g]),
      .full_o      (fifo_full[g])
    );

    mbx_side_ctl u_ctl (
      .clk          (clk),
      .rst_n        (rst_n_sync),
      .ctl_we_i     (side_ctl_we[g]),
      .ctl_wdata_i  (side_ctl_wdata[g]),
      .push_req_i   (side_push[g]),
      .pop_req_i    (side_pop[g]),
      .out_empty_i  (fifo_empty[g]),
      .out_full_i   (fifo_full[g]),
      .in_empty_i   (fifo_empty[PEER]),
      .in_full_i    (fifo_full[PEER]),
      .push_ok_o    (side_push_ok[g]),
      .pop_ok_o     (side_pop_ok[g]),
      .flush_o      (side_flush[g]),
      .ctl_rdata_o  (side_ctl_rdata[g]),
      .irq_drain_o  (side_irq_drain[g]),
      .irq_arrive_o (side_irq_arrive[g])
    );

    assign side_pop_data[g] = side_pop_ok[g] ? fifo_head[PEER] : '0;
  end

endmodule

// File: rtl/mbx_top_chk.sv
module mbx_top_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5,
  parameter int WIDTH = 32
) (
  input logic                 clk,
  input logic                 rst_n_sync,
  input logic                 a_ctl_we,
  input logic [15:0]          a_ctl_wdata,
  input logic [15:0]          a_ctl_rdata,
  input logic [15:0]          b_ctl_rdata,
  input logic                 a_push,
  input logic                 a_pop,
  input logic                 b_pop,
  input logic [WIDTH-1:0]     a_pop_data,
  input logic [WIDTH-1:0]     b_pop_data,
  input logic                 a_irq_send_empty,
  input logic                 b_irq_recv,
  input logic [1:0]           side_push_ok,
  input logic [1:0]           side_pop_ok,
  input logic [1:0][CW-1:0]   fifo_cnt
);

  p_mirror_ab_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (b_ctl_rdata[9:8] == a_ctl_rdata[1:0]));

  p_mirror_ba_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (a_ctl_rdata[9:8] == b_ctl_rdata[1:0]));

  p_capacity_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (fifo_cnt[0] <= CW'(DEPTH)) && (fifo_cnt[1] <= CW'(DEPTH)));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (a_push && a_ctl_rdata[1] && a_ctl_rdata[15] && !b_pop && !a_ctl_we)
      |=> (a_ctl_rdata[1] && a_ctl_rdata[14]));

  p_push_pop_hold_r10: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (side_push_ok[0] && side_pop_ok[1] && !(a_ctl_we && a_ctl_wdata[3]))
      |=> $stable(fifo_cnt[0]));

  p_underflow_zero_r5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (b_pop && b_ctl_rdata[8]) |-> (b_pop_data == '0));

  p_disabled_zero_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (a_pop && !a_ctl_rdata[15]) |-> (a_pop_data == '0));

  p_error_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!a_ctl_we && a_ctl_rdata[14]) |=> a_ctl_rdata[14]);

  p_flush_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (a_ctl_we && a_ctl_wdata[3]) |=> (a_ctl_rdata[0] && b_ctl_rdata[8]));

  p_drain_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    a_irq_send_empty |=> !a_irq_send_empty);

  p_arrive_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    b_irq_recv |=> !b_irq_recv);

endmodule

bind mbx_top mbx_top_chk #(.DEPTH(DEPTH), .CW(CW), .WIDTH(WIDTH)) u_chk (
  .clk              (clk),
  .rst_n_sync       (rst_n_sync),
  .a_ctl_we         (a_ctl_we),
  .a_ctl_wdata      (a_ctl_wdata),
  .a_ctl_rdata      (a_ctl_rdata),
  .b_ctl_rdata      (b_ctl_rdata),
  .a_push           (a_push),
  .a_pop            (a_pop),
  .b_pop            (b_pop),
  .a_pop_data       (a_pop_data),
  .b_pop_data       (b_pop_data),
  .a_irq_send_empty (a_irq_send_empty),
  .b_irq_recv       (b_irq_recv),
  .side_push_ok     (side_push_ok),
  .side_pop_ok      (side_pop_ok),
  .fifo_cnt         (fifo_cnt)
);

// File: tb/mbx_top_tb.sv
module mbx_top_tb;

  localparam int W = 32;
  localparam int D = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          ctl_we  [2];
  logic [15:0]   ctl_wd  [2];
  logic          push    [2];
  logic [W-1:0]  pdata   [2];
  logic          pop     [2];
  logic [15:0]   ctl_rd  [2];
  logic [W-1:0]  pop_dat [2];
  logic          irq_se  [2];
  logic          irq_rv  [2];

  mbx_top #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .a_ctl_we         (ctl_we[0]),
    .a_ctl_wdata      (ctl_wd[0]),
    .a_ctl_rdata      (ctl_rd[0]),
    .a_push           (push[0]),
    .a_push_data      (pdata[0]),
    .a_pop            (pop[0]),
    .a_pop_data       (pop_dat[0]),
    .a_irq_send_empty (irq_se[0]),
    .a_irq_recv       (irq_rv[0]),
    .b_ctl_we         (ctl_we[1]),
    .b_ctl_wdata      (ctl_wd[1]),
    .b_ctl_rdata      (ctl_rd[1]),
    .b_push           (push[1]),
    .b_push_data      (pdata[1]),
    .b_pop            (pop[1]),
    .b_pop_data       (pop_dat[1]),
    .b_irq_send_empty (irq_se[1]),
    .b_irq_recv       (irq_rv[1])
  );

  // reference model: queue index s holds words sent by side s
  logic [W-1:0] mq [2][$];
  bit en_m [2];
  bit err_m [2];
  bit ies_m [2];
  bit ier_m [2];

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_stat(input int s);
    int o;
    logic [15:0] r;
    o = 1 - s;
    r = '0;
    r[15] = en_m[s];
    r[14] = err_m[s];
    r[10] = ier_m[s];
    r[9]  = (mq[o].size() == D);
    r[8]  = (mq[o].size() == 0);
    r[2]  = ies_m[s];
    r[1]  = (mq[s].size() == D);
    r[0]  = (mq[s].size() == 0);
    return r;
  endfunction

  task automatic check_stat(input string tag);
    for (int s = 0; s < 2; s++) chk(tag, {16'h0, ctl_rd[s]}, {16'h0, exp_stat(s)});
  endtask

  task automatic do_ctl(input int s, input logic [15:0] v);
    @(negedge clk);
    ctl_we[s] = 1'b1;
    ctl_wd[s] = v;
    @(negedge clk);
    ctl_we[s] = 1'b0;
    en_m[s]  = v[15];
    ies_m[s] = v[2];
    ier_m[s] = v[10];
    if (v[14]) err_m[s] = 1'b0;
    if (v[3])  mq[s].delete();
  endtask

  task automatic do_push(input int s, input logic [W-1:0] v);
    @(negedge clk);
    push[s]  = 1'b1;
    pdata[s] = v;
    @(negedge clk);
    push[s] = 1'b0;
    if (en_m[s]) begin
      if (mq[s].size() == D) err_m[s] = 1'b1;
      else mq[s].push_back(v);
    end
  endtask

  task automatic do_pop(input int s, input string tag);
    logic [W-1:0] got;
    logic [W-1:0] exp;
    int o;
    o = 1 - s;
    @(negedge clk);
    pop[s] = 1'b1;
    #1 got = pop_dat[s];
    if (!en_m[s]) exp = '0;
    else if (mq[o].size() == 0) begin
      exp = '0;
      err_m[s] = 1'b1;
    end else exp = mq[o].pop_front();
    chk(tag, got, exp);
    @(negedge clk);
    pop[s] = 1'b0;
  endtask

  // push on side s and pop of the same queue by the other side, one cycle
  task automatic do_both(input int s, input logic [W-1:0] v, input string tag);
    logic [W-1:0] got;
    logic [W-1:0] exp;
    int pre;
    pre = mq[s].size();
    @(negedge clk);
    push[s]    = 1'b1;
    pdata[s]   = v;
    pop[1-s]   = 1'b1;
    #1 got = pop_dat[1-s];
    exp = (pre == 0) ? '0 : mq[s].pop_front();
    if (pre == 0) err_m[1-s] = 1'b1;
    if (pre < D) mq[s].push_back(v);
    else err_m[s] = 1'b1;
    chk(tag, got, exp);
    @(negedge clk);
    push[s]  = 1'b0;
    pop[1-s] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int s = 0; s < 2; s++) begin
      ctl_we[s] = 1'b0; ctl_wd[s] = '0; push[s] = 1'b0;
      pdata[s] = '0; pop[s] = 1'b0;
      en_m[s] = 0; err_m[s] = 0; ies_m[s] = 0; ier_m[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    for (int s = 0; s < 2; s++) begin
      chk("R9 reset word", {16'h0, ctl_rd[s]}, 32'h0000_0101);
      chk("R9 irq idle", {30'h0, irq_se[s], irq_rv[s]}, 32'h0);
    end

    // R3: disabled side ignores push, pop returns zero without error
    do_push(0, 32'hDEAD_0001);
    check_stat("R3 push ignored");
    do_pop(1, "R3 disabled pop zero");
    check_stat("R3 no error while disabled");

    // R8: only bits 15, 10, 2 stored
    do_ctl(0, 16'hFFF7);
    chk("R8 writable bits A", {16'h0, ctl_rd[0]}, 32'h0000_8505);
    do_ctl(1, 16'h8404);
    check_stat("R8 status both");

    // R1/R2/R12: fill A->B queue
    for (int i = 0; i < D; i++) begin
      do_push(0, 32'hA500_0000 + i * 32'h0101_0101);
      if (i == 0) begin
        chk("R12 arrive pulse", {31'h0, irq_rv[1]}, 32'h1);
        @(negedge clk);
        chk("R12 pulse one cycle", {31'h0, irq_rv[1]}, 32'h0);
      end
    end
    chk("R2 full A bit1", {31'h0, ctl_rd[0][1]}, 32'h1);
    chk("R4 full mirrored B bit9", {31'h0, ctl_rd[1][9]}, 32'h1);
    check_stat("R4 status after fill");

    // R5: overflow
    do_push(0, 32'hBAD0_BAD0);
    chk("R5 overflow error", {31'h0, ctl_rd[0][14]}, 32'h1);
    check_stat("R2 still full after overflow");

    // R6: error kept by write of 0, cleared by write of 1
    do_ctl(0, 16'h8404);
    chk("R6 error kept", {31'h0, ctl_rd[0][14]}, 32'h1);
    do_ctl(0, 16'hC404);
    chk("R6 error cleared", {31'h0, ctl_rd[0][14]}, 32'h0);

    // R1/R11: drain in order
    for (int i = 0; i < D; i++) begin
      do_pop(1, "R1 order");
      if (i == 0) chk("R11 no pulse early", {31'h0, irq_se[0]}, 32'h0);
    end
    chk("R11 drain pulse", {31'h0, irq_se[0]}, 32'h1);
    @(negedge clk);
    chk("R11 pulse one cycle", {31'h0, irq_se[0]}, 32'h0);

    // R5: underflow
    do_pop(1, "R5 empty pop zero");
    chk("R5 underflow error", {31'h0, ctl_rd[1][14]}, 32'h1);
    check_stat("R5 status after underflow");
    do_ctl(1, 16'hC404);

    // R10: concurrent push and pop
    for (int i = 0; i < 3; i++) do_push(0, 32'h1000_0000 + i);
    do_both(0, 32'h2000_0000, "R10 concurrent pop data");
    do_both(0, 32'h2000_0001, "R10 concurrent pop data");
    check_stat("R10 occupancy kept");
    for (int i = 0; i < 3; i++) do_pop(1, "R10 order after concurrent");
    check_stat("R10 empty after drain");

    // R7: flush of B's outgoing queue
    for (int i = 0; i < 5; i++) do_push(1, 32'h5500_0000 + i);
    chk("R4 A sees words", {31'h0, ctl_rd[0][8]}, 32'h0);
    do_ctl(1, 16'h840C);
    chk("R7 send-empty B", {31'h0, ctl_rd[1][0]}, 32'h1);
    chk("R7 recv-empty A", {31'h0, ctl_rd[0][8]}, 32'h1);
    chk("R7 flush bit reads 0", {31'h0, ctl_rd[1][3]}, 32'h0);
    chk("R11 pulse on flush", {31'h0, irq_se[1]}, 32'h1);
    do_push(1, 32'h7777_0001);
    do_pop(0, "R7 first word after flush");
    check_stat("R7 status after flush");

    // R1: wrap sweep over many fill lengths in both directions
    for (int r = 0; r < 20; r++) begin
      int n;
      n = (r * 7) % (D + 1);
      for (int i = 0; i < n; i++) do_push(r % 2, {r[15:0], i[15:0]});
      check_stat("R2 status at fill level");
      for (int i = 0; i < n; i++) do_pop(1 - (r % 2), "R1 wrap order");
    end
    check_stat("R1 empty after sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule